// File: doc/BRIEF.md
# I2C SCL Bit-Rate Generator

This block produces the SCL clock timing for an I2C master. A reference clock is divided by a power of two, chosen by a 3-bit prescale select. Two 5-bit width values set the low and high halves of the SCL period, counted in prescaled ticks. Each half also gets a fixed number of extra ticks, which covers the input synchronizer and the one-cycle noise filter. The extra is 4 ticks when the prescaler is bypassed and 3 ticks otherwise.

The transfer engine receives three registered signals. One is a drive-low level for the SCL open-drain pad. The other two are one-cycle strobes, one at the start of each low phase and one at the start of each high phase. The bus level comes back through a two-stage synchronizer. The high-phase count does not begin until the synchronized SCL is seen high, so a target that holds SCL low stretches the period.

Configuration is applied while a hold input is asserted. The prescale select is captured only during hold. The width values are sampled at the start of every half period.

Top module: `i2c_scl_rate_gen`

## Requirements
- R1: After a synchronous active-high reset, `scl_drive_low`, `low_phase_start` and `high_phase_start` are all 0.
- R2: While `cfg_hold` is 1, all three outputs stay 0 and `presc_sel` is captured. At the first clock edge that samples `cfg_hold` as 0, a low phase begins and `scl_drive_low` rises.
- R3: A low phase keeps `scl_drive_low` at 1 for exactly (L'+P)·2^k cycles. Here k is the captured prescale select, L' is the effective low width, and P is 4 when k = 0 and 3 otherwise.
- R4: A high phase counts (H'+P)·2^k cycles. Counting starts only once the 2-stage synchronized `scl_in` is high. When `scl_in` follows the release at once, `scl_drive_low` stays 0 for (H'+P)·2^k + 2 cycles.
- R5: Suppose an external device holds SCL low and `scl_in` first goes high during the cycle before edge r. Then the next low phase begins at edge r + 1 + (H'+P)·2^k.
- R6: A width value of 0 behaves as a width of 1 (L' = max(L,1), H' = max(H,1)).
- R7: A width value is sampled when its phase begins. Changing `low_width` or `high_width` during a phase affects only later phases of that kind.
- R8: Changes to `presc_sel` while `cfg_hold` is 0 have no effect until the next hold interval.
- R9: `low_phase_start` is 1 for exactly the first cycle of each low phase, which is the cycle in which `scl_drive_low` rises. `high_phase_start` is 1 for exactly the first cycle in which `scl_drive_low` has fallen. The two strobes are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_hold | input | 1 | Hold generator idle; captures prescale select |
| presc_sel | input | 3 | Prescale select k, divide by 2^k |
| low_width | input | 5 | Low half width in prescaled ticks |
| high_width | input | 5 | High half width in prescaled ticks |
| scl_in | input | 1 | Sensed SCL bus level (asynchronous) |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| low_phase_start | output | 1 | Strobe in first cycle of a low phase |
| high_phase_start | output | 1 | Strobe in first cycle of a high phase |

## Verification
The bench measures every low and high run and compares it with the period formula. The runs cover bypassed and divided prescaling, including the largest divide, and zero-valued widths. A design that applied the wrong fixed padding, or used one padding for both prescale cases, would be off by exactly 2^k cycles. A design that took a zero width literally would produce a phase one tick short. The bench also stretches the high phase by holding SCL low externally. A generator that counted from its own release, rather than from the synchronized bus level, would return low too early. Width and prescale changes made in mid-run expose a design that reloads its counters mid-phase or re-reads the prescale select outside hold.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

  // fixed ticks added to each half period for synchronizer and noise filter
  localparam int PAD_UNDIVIDED = 4;
  localparam int PAD_DIVIDED   = 3;
  localparam int MIN_WIDTH     = 1;

endpackage

// File: rtl/scl_in_sync.sv
module scl_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  generate
    if (STAGES <= 1) begin : g_single
      logic r;
      always_ff @(posedge clk) begin
        if (rst) r <= 1'b1;
        else     r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk) begin
        if (rst) sr <= '1;
        else     sr <= {sr[STAGES-2:0], d};
      end
      assign q = sr[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/scl_tick_gen.sv
module scl_tick_gen #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_mask;

  // terminal count 2^sel - 1 built bit by bit
  generate
    for (genvar i = 0; i < DIV_W; i++) begin : g_mask
      assign div_mask[i] = (int'(sel) > i);
    end
  endgenerate

  assign tick = run && (div_cnt == div_mask);

  always_ff @(posedge clk) begin
    if (rst || clear)
      div_cnt <= '0;
    else if (run)
      div_cnt <= tick ? '0 : div_cnt + DIV_W'(1);
  end

  AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    div_cnt <= div_mask); // R3

  AST_DIV_FROZEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run && !clear |=> $stable(div_cnt)); // R5

endmodule

// File: rtl/scl_phase_ctl.sv
module scl_phase_ctl
  import i2c_scl_pkg::*;
#(
  parameter int WID_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             tick,
  input  logic             scl_hi,
  input  logic             presc_bypass,
  input  logic [WID_W-1:0] low_w,
  input  logic [WID_W-1:0] high_w,
  output logic             drive_low,
  output logic             low_start,
  output logic             high_start,
  output logic             div_run,
  output logic             div_clear
);

  localparam int LEN_W = WID_W + 1;

  scl_phase_e       phase;
  logic [LEN_W-1:0] rem;
  logic [LEN_W-1:0] len_low;
  logic [LEN_W-1:0] len_high;

  function automatic logic [LEN_W-1:0] half_len(input logic [WID_W-1:0] w,
                                                input logic bypass);
    logic [LEN_W-1:0] base;
    base = (w == '0) ? LEN_W'(MIN_WIDTH) : LEN_W'(w);
    return base + (bypass ? LEN_W'(PAD_UNDIVIDED) : LEN_W'(PAD_DIVIDED));
  endfunction

  assign len_low  = half_len(low_w, presc_bypass);
  assign len_high = half_len(high_w, presc_bypass);

  assign div_run   = (phase == PH_LOW) || ((phase == PH_HIGH) && scl_hi);
  assign div_clear = hold || (phase == PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      rem        <= '0;
      drive_low  <= 1'b0;
      low_start  <= 1'b0;
      high_start <= 1'b0;
    end else begin
      low_start  <= 1'b0;
      high_start <= 1'b0;
      if (hold) begin
        phase     <= PH_IDLE;
        rem       <= '0;
        drive_low <= 1'b0;
      end else begin
        case (phase)
          PH_IDLE: begin
            phase     <= PH_LOW;
            rem       <= len_low;
            drive_low <= 1'b1;
            low_start <= 1'b1;
          end
          PH_LOW: begin
            if (tick) begin
              if (rem == LEN_W'(1)) begin
                phase      <= PH_HIGH;
                rem        <= len_high;
                drive_low  <= 1'b0;
                high_start <= 1'b1;
              end else begin
                rem <= rem - LEN_W'(1);
              end
            end
          end
          PH_HIGH: begin
            if (tick) begin
              if (rem == LEN_W'(1)) begin
                phase     <= PH_LOW;
                rem       <= len_low;
                drive_low <= 1'b1;
                low_start <= 1'b1;
              end else begin
                rem <= rem - LEN_W'(1);
              end
            end
          end
          default: begin
            phase     <= PH_IDLE;
            rem       <= '0;
            drive_low <= 1'b0;
          end
        endcase
      end
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    hold |=> (!drive_low && !low_start && !high_start)); // R2

  AST_REM_LIVE: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE) |-> (rem != '0)); // R3

  AST_HIGH_WAITS_BUS: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HIGH && !scl_hi && !hold) |=> $stable(rem)); // R5

  AST_LOW_STROBE_ENTRY: assert property (@(posedge clk) disable iff (rst)
    low_start |-> (drive_low && !$past(drive_low))); // R9

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(low_start && high_start)); // R9

endmodule

// File: rtl/i2c_scl_rate_gen.sv
module i2c_scl_rate_gen #(
  parameter int SEL_W       = 3,
  parameter int WID_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_hold,
  input  logic [SEL_W-1:0] presc_sel,
  input  logic [WID_W-1:0] low_width,
  input  logic [WID_W-1:0] high_width,
  input  logic             scl_in,
  output logic             scl_drive_low,
  output logic             low_phase_start,
  output logic             high_phase_start
);

  logic [SEL_W-1:0] presc_act;
  logic             scl_sync;
  logic             tick;
  logic             div_run;
  logic             div_clear;

  // prescale select is only taken while the generator is held
  always_ff @(posedge clk) begin
    if (rst)           presc_act <= '0;
    else if (cfg_hold) presc_act <= presc_sel;
  end

  scl_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (scl_in),
    .q   (scl_sync)
  );

  scl_tick_gen #(.SEL_W(SEL_W)) u_tick (
    .clk   (clk),
    .rst   (rst),
    .clear (div_clear),
    .run   (div_run),
    .sel   (presc_act),
    .tick  (tick)
  );

  scl_phase_ctl #(.WID_W(WID_W)) u_ctl (
    .clk          (clk),
    .rst          (rst),
    .hold         (cfg_hold),
    .tick         (tick),
    .scl_hi       (scl_sync),
    .presc_bypass (presc_act == '0),
    .low_w        (low_width),
    .high_w       (high_width),
    .drive_low    (scl_drive_low),
    .low_start    (low_phase_start),
    .high_start   (high_phase_start),
    .div_run      (div_run),
    .div_clear    (div_clear)
  );

  AST_PRESC_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !cfg_hold |=> $stable(presc_act)); // R8

endmodule

// File: tb/i2c_scl_rate_gen_tb.sv
`timescale 1ns/100ps
module i2c_scl_rate_gen_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_hold = 1'b1;
  logic [2:0] presc_sel = 3'd0;
  logic [4:0] low_width = 5'd5;
  logic [4:0] high_width = 5'd5;
  logic       slave_hold = 1'b0;
  logic       scl_in;
  logic       scl_drive_low, low_phase_start, high_phase_start;

  // open-drain bus: low if either side pulls
  assign scl_in = !(scl_drive_low || slave_hold);

  always #2.5 clk = ~clk;

  i2c_scl_rate_gen u_dut (
    .clk              (clk),
    .rst              (rst),
    .cfg_hold         (cfg_hold),
    .presc_sel        (presc_sel),
    .low_width        (low_width),
    .high_width       (high_width),
    .scl_in           (scl_in),
    .scl_drive_low    (scl_drive_low),
    .low_phase_start  (low_phase_start),
    .high_phase_start (high_phase_start)
  );

  typedef struct {
    bit    is_low;
    int    len;
    string tag;
  } exp_t;

  exp_t sb[$];
  int   n_checks = 0;
  int   n_fails  = 0;
  bit   done     = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // period formula from the requirements
  function automatic int half(input int w, input int k, input bit hi);
    int n;
    n = ((w == 0) ? 1 : w) + ((k == 0) ? 4 : 3);
    return (n << k) + (hi ? 2 : 0);
  endfunction

  task automatic push(input bit lo, input int len, input string tag);
    exp_t e;
    e.is_low = lo;
    e.len    = len;
    e.tag    = tag;
    sb.push_back(e);
  endtask

  // monitor: measures runs of scl_drive_low and checks strobes
  bit   prev = 0;
  bit   run_valid = 0;
  int   run_len = 0;
  exp_t got;
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst || cfg_hold) begin
        run_valid = 0;
        run_len   = 0;
      end else begin
        chk(low_phase_start == (scl_drive_low && !prev), "R9", "low strobe",
            int'(low_phase_start), int'(scl_drive_low && !prev));
        chk(high_phase_start == (!scl_drive_low && prev), "R9", "high strobe",
            int'(high_phase_start), int'(!scl_drive_low && prev));
        if (scl_drive_low != prev) begin
          if (run_valid && sb.size() > 0) begin
            got = sb.pop_front();
            chk(got.is_low == prev, got.tag, "phase kind",
                int'(prev), int'(got.is_low));
            chk(run_len == got.len, got.tag, prev ? "low length" : "high length",
                run_len, got.len);
          end
          run_valid = 1;
          run_len   = 1;
        end else begin
          run_len++;
        end
      end
      prev = scl_drive_low;
    end
  end

  task automatic wait_high_start();
    do begin
      @(posedge clk);
      #1;
    end while (!high_phase_start);
  endtask

  task automatic drain_and_hold();
    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
    cfg_hold = 1'b1;
  endtask

  task automatic idle_config(input int k, input int lw, input int hw);
    @(negedge clk);
    cfg_hold   = 1'b1;
    presc_sel  = 3'(k);
    low_width  = 5'(lw);
    high_width = 5'(hw);
    repeat (3) begin
      @(negedge clk);
      chk(!scl_drive_low && !low_phase_start && !high_phase_start, "R2",
          "outputs idle during hold",
          int'({scl_drive_low, low_phase_start, high_phase_start}), 0);
    end
  endtask

  task automatic run_cfg(input int k, input int lw, input int hw, input int pairs,
                         input string tlo, input string thi);
    idle_config(k, lw, hw);
    for (int i = 0; i < pairs; i++) begin
      push(1'b1, half(lw, k, 1'b0), tlo);
      push(1'b0, half(hw, k, 1'b1), thi);
    end
    @(negedge clk);
    cfg_hold = 1'b0;
    drain_and_hold();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(!scl_drive_low && !low_phase_start && !high_phase_start, "R1",
        "outputs after reset",
        int'({scl_drive_low, low_phase_start, high_phase_start}), 0);
    rst = 1'b0;

    // R2 release starts low phase in the first edge
    idle_config(0, 2, 2);
    @(negedge clk);
    cfg_hold = 1'b0;
    @(negedge clk);
    chk(scl_drive_low && low_phase_start, "R2", "low phase begins after release",
        int'({scl_drive_low, low_phase_start}), 3);

    // R3 / R4 formula across prescale values
    run_cfg(0, 5, 7, 2, "R3", "R4");
    run_cfg(1, 3, 2, 2, "R3", "R4");
    run_cfg(3, 10, 4, 1, "R3", "R4");
    run_cfg(2, 31, 31, 1, "R3", "R4");
    run_cfg(7, 1, 2, 1, "R3", "R4");

    // R6 zero widths act as one
    run_cfg(0, 0, 0, 2, "R6", "R6");
    run_cfg(2, 0, 3, 1, "R6", "R4");

    // R7 width change mid-phase applies to the next phase only
    idle_config(0, 5, 6);
    push(1'b1, half(5, 0, 1'b0), "R7");
    push(1'b0, half(6, 0, 1'b1), "R7");
    push(1'b1, half(9, 0, 1'b0), "R7");
    push(1'b0, half(3, 0, 1'b1), "R7");
    @(negedge clk);
    cfg_hold = 1'b0;
    repeat (3) @(negedge clk);
    low_width = 5'd9;
    wait_high_start();
    @(negedge clk);
    high_width = 5'd3;
    drain_and_hold();

    // R8 prescale change while running is ignored
    idle_config(1, 4, 2);
    for (int i = 0; i < 3; i++) begin
      push(1'b1, half(4, 1, 1'b0), "R8");
      push(1'b0, half(2, 1, 1'b1), "R8");
    end
    @(negedge clk);
    cfg_hold = 1'b0;
    repeat (2) @(negedge clk);
    presc_sel = 3'd4;
    drain_and_hold();
    run_cfg(4, 1, 1, 1, "R8", "R8");

    // R5 external device stretches the high phase
    idle_config(1, 2, 3);
    slave_hold = 1'b1;
    push(1'b1, half(2, 1, 1'b0), "R3");
    push(1'b0, half(3, 1, 1'b1) + 7, "R5");
    push(1'b1, half(2, 1, 1'b0), "R3");
    push(1'b0, half(3, 1, 1'b1), "R4");
    @(negedge clk);
    cfg_hold = 1'b0;
    wait_high_start();
    repeat (8) @(negedge clk);
    slave_hold = 1'b0;
    drain_and_hold();

    // R5 longer stretch with undivided clock
    idle_config(0, 3, 1);
    slave_hold = 1'b1;
    push(1'b1, half(3, 0, 1'b0), "R3");
    push(1'b0, half(1, 0, 1'b1) + 20, "R5");
    @(negedge clk);
    cfg_hold = 1'b0;
    wait_high_start();
    repeat (21) @(negedge clk);
    slave_hold = 1'b0;
    drain_and_hold();

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R3", "scoreboard drained", sb.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL R3 watchdog: actual %0d pending phases expected 0", sb.size());
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule